// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two 32-bit entries in sequence from a page table held in memory. The requester gives a virtual address, an access type (read or write) and a privilege (kernel or user). The block takes a base frame number for the top-level table, which it samples when it accepts the request. It then reads the directory entry and checks it. If that entry passes, it reads the leaf entry and checks it in the same way. It returns either the translated address or a fault that gives the cause and the level. There is one memory read in flight at a time, and a new request is taken only when the walker is idle.

The controller has five states. **IDLE** is the only state that accepts a request. **FETCH_DIR** holds the directory read until it returns. **FETCH_PTE** holds the leaf read until it returns. **DONE** presents a good translation for one cycle. **FAULT** presents a fault for one cycle. The transitions are as follows:
- IDLE→FETCH_DIR on an accepted request.
- FETCH_DIR→FETCH_PTE when the directory entry passes its check.
- FETCH_DIR→FAULT when the directory entry fails its check.
- FETCH_PTE→DONE when the leaf entry passes its check.
- FETCH_PTE→FAULT when the leaf entry fails its check.
- DONE→IDLE and FAULT→IDLE unconditionally.

Every entry uses the same layout: bit 0 marks the entry present, bit 1 allows writes, bit 2 allows user access, and bits 31:12 hold a frame number. Bits 11:3 are ignored.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: `req_ready` is 1 exactly in IDLE. A request is accepted only on a cycle with `req_valid` and `req_ready` both high. At acceptance the block captures `req_vaddr`, `req_write`, `req_user` and `ptbr_frame`, and later changes on those inputs have no effect on the walk under way.
- R3: The directory read begins in the cycle after acceptance, at address `ptbr_frame*4096 + vaddr[31:22]*4`. `mem_req` and `mem_addr` stay constant until a cycle with `mem_rvalid` high.
- R4: When the directory entry passes its check, the leaf read begins in the next cycle, at address `dir_entry[31:12]*4096 + vaddr[21:12]*4`.
- R5: In the cycle after the leaf entry returns and passes, `rsp_valid` is 1 for one cycle with `rsp_fault`=0, `rsp_fault_kind`=2'b00 and `rsp_paddr = {leaf[31:12], vaddr[11:0]}`.
- R6: An entry with bit 0 clear, at either level, gives a fault in the next cycle: `rsp_fault`=1, `rsp_fault_kind`=2'b01, and `rsp_fault_lvl` set to 0 for the directory or 1 for the leaf. No further read is issued.
- R7: A write request needs bit 1 set in both entries. The first entry without it gives fault kind 2'b10 at that level.
- R8: A user request needs bit 2 set in both entries. The first entry without it gives fault kind 2'b11. A kernel request (`req_user`=0) ignores bit 2, and a read ignores bit 1.
- R9: Within one entry, the causes rank not-present (01) over write-denied (10) over user-denied (11).
- R10: `mem_rvalid` and `mem_rdata` have no effect while `mem_req` is 0.
- R11: A response lasts one cycle, and the walker is back in IDLE (`req_ready`=1) in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ptbr_frame | input | 20 | Frame number of the top-level table, sampled at acceptance |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user-mode access, 0 = kernel |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_fault | output | 1 | Response is a fault |
| rsp_fault_kind | output | 2 | 00 none, 01 not present, 10 write denied, 11 user denied |
| rsp_fault_lvl | output | 1 | Level of the fault: 0 directory, 1 leaf |
| rsp_paddr | output | 32 | Translated physical address |
| mem_req | output | 1 | Entry read pending |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 32 | Entry returned by memory |

## Verification
The bound checker tests a set of properties on every cycle:
- no read while idle;
- a read starts the cycle after acceptance;
- the read address stays stable while the read waits;
- entry addresses are word-aligned;
- responses last exactly one cycle and follow a returned read;
- a good response carries the request's page offset and a zero fault code.

Other behaviour depends on table contents and on how the bench sequences its stimulus, so only the bench scenarios can show it. This covers the exact entry addresses at each level, and the fault cause and level for each combination of flags. It also covers the ranking of causes within one entry and the capture of the base frame and request at acceptance. Finally, it covers the handling of stray read-valid pulses and of memory latency ranging from zero to several cycles.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_DIR,
        ST_FETCH_PTE,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'b00,
        FLT_ABSENT   = 2'b01,
        FLT_NO_WRITE = 2'b10,
        FLT_NO_USER  = 2'b11
    } fault_e;

    // flag bits at the bottom of every entry
    localparam int FLAG_W      = 3;
    localparam int PRESENT_BIT = 0;
    localparam int WRITE_BIT   = 1;
    localparam int USER_BIT    = 2;

    typedef struct packed {
        logic user;
        logic write;
        logic present;
    } entry_flags_t;

    typedef struct packed {
        logic write;
        logic user;
    } access_t;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int PA_W        = 32,
    parameter int OFF_W       = 12,
    parameter int IDX_W       = 10,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [PA_W-OFF_W-1:0] frame_i,
    input  logic [IDX_W-1:0]      idx_i,
    output logic [PA_W-1:0]       addr_o
);
    localparam int ESH = $clog2(ENTRY_BYTES);

    logic [PA_W-1:0] table_base;
    logic [PA_W-1:0] entry_off;

    always_comb begin
        table_base = {frame_i, {OFF_W{1'b0}}};
        entry_off  = PA_W'(idx_i) << ESH;
        addr_o     = table_base + entry_off;
    end
endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
    import pt_walk_pkg::*;
(
    input  entry_flags_t flags_i,
    input  access_t      acc_i,
    output fault_e       code_o,
    output logic         ok_o
);
    always_comb begin
        code_o = FLT_NONE;
        if (!flags_i.present) begin
            code_o = FLT_ABSENT;
        end else if (acc_i.write && !flags_i.write) begin
            code_o = FLT_NO_WRITE;
        end else if (acc_i.user && !flags_i.user) begin
            code_o = FLT_NO_USER;
        end
        ok_o = (code_o == FLT_NONE);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter  int IDX_W   = 10,
    parameter  int OFF_W   = 12,
    parameter  int PA_W    = 32,
    parameter  int ENTRY_W = 32,
    localparam int VA_W    = 2 * IDX_W + OFF_W,
    localparam int FRAME_W = PA_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] ptbr_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    input  logic               req_user,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [1:0]         rsp_fault_kind,
    output logic               rsp_fault_lvl,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               mem_req,
    output logic [PA_W-1:0]    mem_addr,
    input  logic               mem_rvalid,
    input  logic [ENTRY_W-1:0] mem_rdata
);
    localparam int ENTRY_BYTES = ENTRY_W / 8;

    walk_state_e        state_q, state_d;
    logic [VA_W-1:0]    va_q;
    access_t            acc_q;
    logic [FRAME_W-1:0] base_q;
    logic [FRAME_W-1:0] dir_frame_q;
    logic [PA_W-1:0]    paddr_q;
    fault_e             kind_q;
    logic               lvl_q;

    logic               accept;
    logic               fetching;
    logic               rd_fire;
    logic [IDX_W-1:0]   dir_idx;
    logic [IDX_W-1:0]   tbl_idx;
    logic [FRAME_W-1:0] gen_frame;
    logic [IDX_W-1:0]   gen_idx;
    logic [FRAME_W-1:0] entry_frame;
    entry_flags_t       entry_flags;
    fault_e             chk_code;
    logic               chk_ok;
    logic               unused_rdata;

    assign accept      = req_valid && (state_q == ST_IDLE);
    assign fetching    = (state_q == ST_FETCH_DIR) || (state_q == ST_FETCH_PTE);
    assign rd_fire     = fetching && mem_rvalid;
    assign dir_idx     = va_q[OFF_W+IDX_W +: IDX_W];
    assign tbl_idx     = va_q[OFF_W +: IDX_W];
    assign entry_frame = mem_rdata[OFF_W +: FRAME_W];
    assign entry_flags = '{user:    mem_rdata[USER_BIT],
                           write:   mem_rdata[WRITE_BIT],
                           present: mem_rdata[PRESENT_BIT]};
    assign unused_rdata = ^mem_rdata[OFF_W-1:FLAG_W];

    // address source follows the walk level
    always_comb begin
        if (state_q == ST_FETCH_PTE) begin
            gen_frame = dir_frame_q;
            gen_idx   = tbl_idx;
        end else begin
            gen_frame = base_q;
            gen_idx   = dir_idx;
        end
    end

    pt_addr_gen #(
        .PA_W        (PA_W),
        .OFF_W       (OFF_W),
        .IDX_W       (IDX_W),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_addr_gen (
        .frame_i (gen_frame),
        .idx_i   (gen_idx),
        .addr_o  (mem_addr)
    );

    pt_entry_check u_entry_check (
        .flags_i (entry_flags),
        .acc_i   (acc_q),
        .code_o  (chk_code),
        .ok_o    (chk_ok)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_FETCH_DIR;
            end
            ST_FETCH_DIR: begin
                if (mem_rvalid) state_d = chk_ok ? ST_FETCH_PTE : ST_FAULT;
            end
            ST_FETCH_PTE: begin
                if (mem_rvalid) state_d = chk_ok ? ST_DONE : ST_FAULT;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_FETCH_DIR: mem_req   = 1'b1;
            ST_FETCH_PTE: mem_req   = 1'b1;
            ST_DONE:      rsp_valid = 1'b1;
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
            end
            default: req_ready = 1'b0;
        endcase
    end

    assign rsp_fault_kind = kind_q;
    assign rsp_fault_lvl  = lvl_q;
    assign rsp_paddr      = paddr_q;

    // walk context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q        <= '0;
            acc_q       <= '0;
            base_q      <= '0;
            dir_frame_q <= '0;
            paddr_q     <= '0;
            kind_q      <= FLT_NONE;
            lvl_q       <= 1'b0;
        end else begin
            if (accept) begin
                va_q   <= req_vaddr;
                acc_q  <= '{write: req_write, user: req_user};
                base_q <= ptbr_frame;
                kind_q <= FLT_NONE;
                lvl_q  <= 1'b0;
            end
            if (rd_fire) begin
                kind_q <= chk_code;
                if (state_q == ST_FETCH_DIR) begin
                    dir_frame_q <= entry_frame;
                    lvl_q       <= 1'b0;
                end else begin
                    paddr_q <= {entry_frame, va_q[OFF_W-1:0]};
                    lvl_q   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int OFF_W = 12,
    parameter int PA_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [OFF_W-1:0] va_off,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [1:0]       rsp_fault_kind,
    input logic [OFF_W-1:0] pa_off,
    input logic             mem_req,
    input logic [PA_W-1:0]  mem_addr,
    input logic             mem_rvalid
);
    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= '0;
        else if (req_valid && req_ready) off_q <= va_off;
    end

    AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid)); // R2
    AST_FETCH_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_req); // R3
    AST_FETCH_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R3
    AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R4
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R11
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mem_req && mem_rvalid)); // R5
    AST_OK_NO_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_fault_kind == 2'b00)); // R5
    AST_PADDR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (pa_off == off_q)); // R5
    AST_FAULT_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_fault_kind != 2'b00)); // R6
endmodule

bind pt_walker pt_walker_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_walker_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .va_off         (req_vaddr[OFF_W-1:0]),
    .rsp_valid      (rsp_valid),
    .rsp_fault      (rsp_fault),
    .rsp_fault_kind (rsp_fault_kind),
    .pa_off         (rsp_paddr[OFF_W-1:0]),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .mem_rvalid     (mem_rvalid)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] ptbr_frame;
    logic        req_valid, req_ready, req_write, req_user;
    logic [31:0] req_vaddr;
    logic        rsp_valid, rsp_fault, rsp_fault_lvl;
    logic [1:0]  rsp_fault_kind;
    logic [31:0] rsp_paddr;
    logic        mem_req, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;

    always #4 clk = ~clk; // 125 MHz

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .ptbr_frame(ptbr_frame),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_fault_kind(rsp_fault_kind),
        .rsp_fault_lvl(rsp_fault_lvl), .rsp_paddr(rsp_paddr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [31:0] tmem [int unsigned];
    int lat = 0;
    int wait_cnt = 0;
    bit stray = 0;

    // reference model
    int          ph = 0; // 0 idle, 1 dir read, 2 leaf read, 3 good rsp, 4 fault rsp
    logic [31:0] m_va;
    bit          m_wr, m_us;
    logic [19:0] m_base, m_dir;
    logic [31:0] m_pa;
    logic [1:0]  m_kind;
    bit          m_lvl;
    logic [1:0]  obs_kind;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] fcode(logic [31:0] e, bit wr, bit us);
        if (!e[0]) return 2'b01;
        if (wr && !e[1]) return 2'b10;
        if (us && !e[2]) return 2'b11;
        return 2'b00;
    endfunction

    function automatic string kind_req(logic [1:0] k);
        case (k)
            2'b01:   return "R6";
            2'b10:   return "R7";
            default: return "R8";
        endcase
    endfunction

    // one clock: inputs already set, called just after a falling edge
    task automatic tick();
        logic [31:0] e;
        logic [1:0]  c;
        #1;
        if (mem_req) begin
            mem_rvalid = (wait_cnt >= lat);
            mem_rdata  = tmem.exists(mem_addr) ? tmem[mem_addr] : 32'h0;
        end else begin
            mem_rvalid = stray;
            mem_rdata  = 32'hFFFF_FFFF;
        end
        #1;
        chk("R2", "req_ready", req_ready, (ph == 0));
        chk("R3", "mem_req", mem_req, (ph == 1 || ph == 2));
        chk("R11", "rsp_valid", rsp_valid, (ph >= 3));
        if (ph == 1)
            chk("R3", "dir addr", mem_addr, {m_base, 12'h0} + {20'h0, m_va[31:22], 2'b00});
        if (ph == 2)
            chk("R4", "leaf addr", mem_addr, {m_dir, 12'h0} + {20'h0, m_va[21:12], 2'b00});
        if (ph == 3) begin
            chk("R5", "rsp_fault", rsp_fault, 0);
            chk("R5", "kind", rsp_fault_kind, 0);
            chk("R5", "paddr", rsp_paddr, m_pa);
        end
        if (ph == 4) begin
            chk(kind_req(m_kind), "rsp_fault", rsp_fault, 1);
            chk(kind_req(m_kind), "kind", rsp_fault_kind, m_kind);
            chk(kind_req(m_kind), "level", rsp_fault_lvl, m_lvl);
        end
        if (rsp_valid) obs_kind = rsp_fault_kind;
        case (ph)
            0: if (req_valid) begin
                m_va = req_vaddr; m_wr = req_write; m_us = req_user; m_base = ptbr_frame;
                ph = 1;
            end
            1: if (mem_rvalid) begin
                e = mem_rdata; c = fcode(e, m_wr, m_us);
                if (c != 0) begin m_kind = c; m_lvl = 0; ph = 4; end
                else begin m_dir = e[31:12]; ph = 2; end
            end
            2: if (mem_rvalid) begin
                e = mem_rdata; c = fcode(e, m_wr, m_us);
                if (c != 0) begin m_kind = c; m_lvl = 1; ph = 4; end
                else begin m_pa = {e[31:12], m_va[11:0]}; ph = 3; end
            end
            default: ph = 0;
        endcase
        if (mem_req && !mem_rvalid) wait_cnt++;
        else wait_cnt = 0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic map_page(logic [19:0] base, logic [31:0] va, logic [2:0] dfl,
                            logic [19:0] tfr, logic [2:0] pfl, logic [19:0] pfn);
        tmem[{base, 12'h0} + {20'h0, va[31:22], 2'b00}] = {tfr, 9'h0, dfl};
        tmem[{tfr, 12'h0} + {20'h0, va[21:12], 2'b00}]  = {pfn, 9'h0, pfl};
    endtask

    task automatic walk(logic [31:0] va, bit wr, bit us, logic [19:0] base,
                        int latency, bit scramble);
        lat = latency;
        req_valid = 1; req_vaddr = va; req_write = wr; req_user = us; ptbr_frame = base;
        tick();
        if (scramble) begin
            req_vaddr = ~va; req_write = ~wr; req_user = ~us; ptbr_frame = base + 20'h1;
        end else begin
            req_valid = 0;
        end
        for (int g = 0; g < 64 && ph != 0; g++) begin
            if (ph >= 3) req_valid = 0;
            tick();
        end
        req_valid = 0;
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_vaddr = 0; req_write = 0; req_user = 0;
        ptbr_frame = 0; mem_rvalid = 0; mem_rdata = 0;
        // table contents: flags P=1 W=2 U=4
        map_page(20'h00010, 32'h0040_3123, 3'd7, 20'h00020, 3'd7, 20'hABCDE);
        map_page(20'h00010, 32'h0080_0000, 3'd0, 20'h00021, 3'd7, 20'h11111);
        map_page(20'h00010, 32'h00C0_5000, 3'd7, 20'h00022, 3'd6, 20'h22222);
        map_page(20'h00010, 32'h00C0_6000, 3'd7, 20'h00022, 3'd0, 20'h22223);
        map_page(20'h00010, 32'h0100_0000, 3'd5, 20'h00023, 3'd7, 20'h33333);
        map_page(20'h00010, 32'h0140_1000, 3'd7, 20'h00024, 3'd5, 20'h44444);
        map_page(20'h00010, 32'h0180_2000, 3'd3, 20'h00025, 3'd7, 20'h55550);
        map_page(20'h00010, 32'h01C0_3000, 3'd7, 20'h00026, 3'd1, 20'h66666);
        map_page(20'h00011, 32'h0040_3123, 3'd7, 20'h00030, 3'd7, 20'h55555);
        repeat (3) @(negedge clk);
        chk("R1", "req_ready in reset", req_ready, 1);
        chk("R1", "rsp_valid in reset", rsp_valid, 0);
        chk("R1", "mem_req in reset", mem_req, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "req_ready after reset", req_ready, 1);

        walk(32'h0040_3123, 0, 1, 20'h00010, 0, 0);   // R5 user read
        walk(32'h0040_3FFF, 1, 0, 20'h00010, 3, 0);   // R5 kernel write, slow memory
        walk(32'h0040_3123, 0, 0, 20'h00011, 1, 0);   // R3 other base
        walk(32'h0080_0000, 0, 0, 20'h00010, 0, 0);   // R6 dir absent
        walk(32'h00C0_5000, 0, 0, 20'h00010, 2, 0);   // R6 leaf absent
        walk(32'h00C0_6000, 1, 1, 20'h00010, 0, 0);   // R9 absent ranks first
        chk("R9", "absent over others", obs_kind, 2'b01);
        walk(32'h0100_0000, 1, 0, 20'h00010, 0, 0);   // R7 dir no write
        walk(32'h0100_0000, 0, 1, 20'h00010, 0, 0);   // R8 read ignores write bit
        walk(32'h0140_1000, 1, 0, 20'h00010, 1, 0);   // R7 leaf no write
        walk(32'h0180_2000, 0, 1, 20'h00010, 0, 0);   // R8 dir no user
        walk(32'h0180_2000, 1, 0, 20'h00010, 0, 0);   // R8 kernel ignores user bit
        walk(32'h01C0_3000, 1, 1, 20'h00010, 0, 0);   // R9 write over user
        chk("R9", "write over user", obs_kind, 2'b10);

        // R10: stray read-valid pulses while idle
        stray = 1;
        for (int i = 0; i < 5; i++) tick();
        stray = 0;
        chk("R10", "mem_req after stray", mem_req, 0);
        chk("R10", "rsp_valid after stray", rsp_valid, 0);
        chk("R10", "req_ready after stray", req_ready, 1);

        // R2: inputs scrambled during the walk
        walk(32'h0040_3123, 0, 1, 20'h00010, 2, 1);

        // R11: back-to-back requests with req_valid held
        lat = 1; req_valid = 1; req_vaddr = 32'h0040_3123; req_write = 0; req_user = 0;
        ptbr_frame = 20'h00010;
        for (int i = 0; i < 24; i++) tick();
        req_valid = 0;
        for (int g = 0; g < 64 && ph != 0; g++) tick();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule